// File: doc/BRIEF.md
# Host Interrupt Aggregator with Coalescing Delay

This block gathers single-cycle cause pulses from device logic and from a DMA flow handler into a 32-bit host status word. It drives one interrupt line to the host. Every status bit stays set until the host writes a 1 to its position. A host mask word picks which status bits may raise the line. Flow-handler pulses are kept in a status word of their own. They are also folded into three summary bits of the host word: receive, error and transmit.

To cut the interrupt rate, a coalescing timer holds the line back. Its delay is a programmed number of 32-microsecond units, and it is paced by a 1-µs tick input. A high-priority receive pulse skips the delay. A second byte of the same control word runs a periodic timer. Each time that timer expires, it sets a receive-tick cause in the host word. Software reaches the four registers over a simple word-indexed write strobe with combinational read data.

Top module: `hirq_coalescer`

## Requirements
- R1: Host status bits are cleared only by a status write carrying 1 in that position. A written 0 leaves the bit unchanged. When a cause pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R2: The flow-handler status word latches pulses on bit 31 (DMA error), bit 30 (high-priority receive), bits 17/16 (receive channels 1/0) and bits 1/0 (transmit channels 1/0). Other input bits are ignored. The word is cleared by writing 1s, like the host word.
- R3: A flow-handler pulse on bit 30, 17 or 16 sets host bit 31. A pulse on bit 31 sets host bit 29. A pulse on bit 1 or 0 sets host bit 27.
- R4: The direct cause inputs latch only on host bits 26, 25, 7, 6, 3, 1 and 0 (direct-cause mask 0x060000CB). Pulses on any other bit, including 31, 29, 28 and 27, are ignored.
- R5: The interrupt line is never high while (host status AND host mask) is zero. Masked causes still latch.
- R6: With a coalescing value C > 0, the timer starts in the cycle after an unmasked cause first becomes pending. The line rises on the clock edge of the 32*C-th tick after that start. Cycles without a tick do not advance the timer.
- R7: With C = 0, the line rises on the edge after the cause is latched.
- R8: A flow-handler bit-30 pulse, when host mask bit 31 is set, raises the line on the same edge that latches it, whatever the value of C.
- R9: A nonzero periodic byte P sets host bit 28 every 32*P ticks. The first expiry comes 32*P ticks after the first tick that follows the control write. P = 0 never sets bit 28.
- R10: After reset, host status, host mask and flow-handler status read 0, the control word reads 0x00000040 (C = 0x40, P = 0), and the line is low.
- R11: The line stays high while any unmasked bit is pending. Once the host clears them all, the line drops, and the next cause waits the full delay again.
- R12: Register index 0 is host status, 1 is host mask, 2 is flow-handler status and 3 is control (C in bits 7:0, P in bits 15:8). Read data follows the index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| host_evt | input | 32 | Direct cause pulses, one per host bit |
| fh_evt | input | 32 | Flow-handler cause pulses |
| irq | output | 1 | Host interrupt line |

## Verification
The bench measures the exact edge on which the line rises: for the reset delay, for a one-unit delay, with the tick gated off partway through, and for zero delay. An off-by-one in the tick counter or in its start cycle would move that edge and fail the check.

It also checks three behaviours that a faulty design would miss. A bypass pulse must raise the line at once under the maximum delay. A plain receive pulse must not. A pulse that coincides with a clear of the same bit must leave the bit set.

The bench clears the pending bits one at a time and confirms the line falls only after the last one is cleared. It then checks that the following cause waits the full delay, which a design that never re-armed its timer would fail. The periodic timer is checked on two consecutive expiries, and then checked to stay silent once disabled.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

    localparam int DATA_W = 32;

    // host status bit positions driven by folded or timer causes
    localparam int HB_FH_RX    = 31;
    localparam int HB_FH_ERR   = 29;
    localparam int HB_PERIODIC = 28;
    localparam int HB_FH_TX    = 27;

    // host bits that direct cause inputs may set: 26,25,7,6,3,1,0
    localparam logic [DATA_W-1:0] HOST_DIRECT_MASK = 32'h0600_00CB;

    // flow-handler word layout
    localparam int FH_ERR_BIT   = 31;
    localparam int FH_HIPRI_BIT = 30;
    localparam logic [DATA_W-1:0] FH_IMPL_MASK = 32'hC003_0003;
    localparam logic [DATA_W-1:0] FH_RX_MASK   = 32'h4003_0000;
    localparam logic [DATA_W-1:0] FH_TX_MASK   = 32'h0000_0003;

    localparam int REG_IDX_W = 2;
    localparam int PER_LSB   = 8;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_HSTAT = 2'd0,
        REG_HMASK = 2'd1,
        REG_FSTAT = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CO_IDLE = 2'd0,
        CO_WAIT = 2'd1,
        CO_FIRE = 2'd2
    } coal_state_e;

endpackage

// File: rtl/hirq_cause_regs.sv
module hirq_cause_regs
    import hirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] host_evt,
    input  logic [DATA_W-1:0] fh_evt,
    input  logic              per_hit,
    input  logic [DATA_W-1:0] host_clr,
    input  logic [DATA_W-1:0] fh_clr,
    output logic [DATA_W-1:0] host_stat,
    output logic [DATA_W-1:0] fh_stat
);

    typedef struct packed {
        logic [DATA_W-1:0] host;
        logic [DATA_W-1:0] fh;
    } cause_t;

    cause_t cur_q, nxt_d;
    logic [DATA_W-1:0] host_set;
    logic [DATA_W-1:0] fh_set;

    always_comb begin
        fh_set   = fh_evt & FH_IMPL_MASK;
        host_set = host_evt & HOST_DIRECT_MASK;
        host_set[HB_FH_RX]    = |(fh_evt & FH_RX_MASK);
        host_set[HB_FH_ERR]   = fh_evt[FH_ERR_BIT];
        host_set[HB_FH_TX]    = |(fh_evt & FH_TX_MASK);
        host_set[HB_PERIODIC] = per_hit;

        // a set in the same cycle as a clear keeps the bit
        nxt_d.host = (cur_q.host & ~host_clr) | host_set;
        nxt_d.fh   = (cur_q.fh & ~fh_clr) | fh_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign host_stat = cur_q.host;
    assign fh_stat   = cur_q.fh;

endmodule

// File: rtl/hirq_coal_fsm.sv
module hirq_coal_fsm
    import hirq_pkg::*;
#(
    parameter int COAL_W    = 8,
    parameter int UNIT_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              pending,
    input  logic              bypass,
    input  logic [COAL_W-1:0] coal_val,
    output logic              irq
);

    localparam int CNT_W = COAL_W + UNIT_LOG2;

    typedef struct packed {
        coal_state_e      st;
        logic [CNT_W-1:0] cnt;
    } coal_t;

    coal_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (bypass) begin
            nxt_d.st  = CO_FIRE;
            nxt_d.cnt = '0;
        end else begin
            case (cur_q.st)
                CO_IDLE: begin
                    if (pending) begin
                        if (coal_val == '0) begin
                            nxt_d.st = CO_FIRE;
                        end else begin
                            nxt_d.st  = CO_WAIT;
                            nxt_d.cnt = {coal_val, {UNIT_LOG2{1'b0}}};
                        end
                    end
                end
                CO_WAIT: begin
                    if (!pending) begin
                        nxt_d.st  = CO_IDLE;
                        nxt_d.cnt = '0;
                    end else if (us_tick) begin
                        if (cur_q.cnt == CNT_W'(1)) begin
                            nxt_d.st  = CO_FIRE;
                            nxt_d.cnt = '0;
                        end else begin
                            nxt_d.cnt = cur_q.cnt - CNT_W'(1);
                        end
                    end
                end
                CO_FIRE: begin
                    if (!pending) begin
                        nxt_d.st = CO_IDLE;
                    end
                end
                default: begin
                    nxt_d.st  = CO_IDLE;
                    nxt_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st  <= CO_IDLE;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign irq = (cur_q.st == CO_FIRE) && pending;

endmodule

// File: rtl/hirq_periodic.sv
module hirq_periodic #(
    parameter int PER_W     = 8,
    parameter int UNIT_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             restart,
    input  logic [PER_W-1:0] per_val,
    output logic             expire
);

    localparam int CNT_W = PER_W + UNIT_LOG2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } per_t;

    per_t cur_q, nxt_d;
    logic [CNT_W-1:0] reload;

    always_comb begin
        reload = {per_val, {UNIT_LOG2{1'b0}}};
        nxt_d  = cur_q;
        expire = 1'b0;
        if (restart || per_val == '0) begin
            nxt_d.cnt = '0;
        end else if (us_tick) begin
            if (cur_q.cnt == '0) begin
                // first tick after enable only arms the counter
                nxt_d.cnt = reload;
            end else if (cur_q.cnt == CNT_W'(1)) begin
                expire    = 1'b1;
                nxt_d.cnt = reload;
            end else begin
                nxt_d.cnt = cur_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/hirq_coalescer.sv
module hirq_coalescer
    import hirq_pkg::*;
#(
    parameter int                COAL_W     = 8,
    parameter int                UNIT_LOG2  = 5,
    parameter logic [COAL_W-1:0] COAL_RESET = 8'h40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 us_tick,
    input  logic                 reg_wr,
    input  logic [REG_IDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [DATA_W-1:0]    host_evt,
    input  logic [DATA_W-1:0]    fh_evt,
    output logic                 irq
);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [COAL_W-1:0] coal;
        logic [COAL_W-1:0] per;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [DATA_W-1:0] host_clr;
    logic [DATA_W-1:0] fh_clr;
    logic              per_restart;
    logic              per_hit;
    logic [DATA_W-1:0] host_stat;
    logic [DATA_W-1:0] fh_stat;
    logic [DATA_W-1:0] host_mask;
    logic [COAL_W-1:0] per_val;
    logic              pending;
    logic              bypass;

    always_comb begin
        ctl_d       = ctl_q;
        host_clr    = '0;
        fh_clr      = '0;
        per_restart = 1'b0;
        if (reg_wr) begin
            case (reg_sel_e'(reg_addr))
                REG_HSTAT: host_clr = reg_wdata;
                REG_HMASK: ctl_d.mask = reg_wdata;
                REG_FSTAT: fh_clr = reg_wdata;
                REG_CTRL: begin
                    ctl_d.coal  = reg_wdata[COAL_W-1:0];
                    ctl_d.per   = reg_wdata[PER_LSB +: COAL_W];
                    per_restart = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            REG_HSTAT: reg_rdata = host_stat;
            REG_HMASK: reg_rdata = ctl_q.mask;
            REG_FSTAT: reg_rdata = fh_stat;
            REG_CTRL: begin
                reg_rdata[COAL_W-1:0]        = ctl_q.coal;
                reg_rdata[PER_LSB +: COAL_W] = ctl_q.per;
            end
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.mask <= '0;
            ctl_q.coal <= COAL_RESET;
            ctl_q.per  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign host_mask = ctl_q.mask;
    assign per_val   = ctl_q.per;
    assign pending   = |(host_stat & ctl_q.mask);
    assign bypass    = fh_evt[FH_HIPRI_BIT] & ctl_q.mask[HB_FH_RX];

    hirq_cause_regs u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_evt (host_evt),
        .fh_evt   (fh_evt),
        .per_hit  (per_hit),
        .host_clr (host_clr),
        .fh_clr   (fh_clr),
        .host_stat(host_stat),
        .fh_stat  (fh_stat)
    );

    hirq_periodic #(
        .PER_W    (COAL_W),
        .UNIT_LOG2(UNIT_LOG2)
    ) u_periodic (
        .clk    (clk),
        .rst_n  (rst_n),
        .us_tick(us_tick),
        .restart(per_restart),
        .per_val(ctl_q.per),
        .expire (per_hit)
    );

    hirq_coal_fsm #(
        .COAL_W   (COAL_W),
        .UNIT_LOG2(UNIT_LOG2)
    ) u_coal (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .pending (pending),
        .bypass  (bypass),
        .coal_val(ctl_q.coal),
        .irq     (irq)
    );

endmodule

// File: rtl/hirq_coalescer_chk.sv
module hirq_coalescer_chk
    import hirq_pkg::*;
#(
    parameter int COAL_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq,
    input logic                 reg_wr,
    input logic [REG_IDX_W-1:0] reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [DATA_W-1:0]    host_evt,
    input logic [DATA_W-1:0]    fh_evt,
    input logic [DATA_W-1:0]    host_stat,
    input logic [DATA_W-1:0]    host_mask,
    input logic [COAL_W-1:0]    per_val
);

    assert_irq_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((host_stat & host_mask) != '0));

    // R1: a bit may only drop when the previous cycle wrote 1 to it
    assert_w1c_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(host_stat) & ~host_stat &
                   ~(($past(reg_wr) && $past(reg_addr) == 2'd0) ? $past(reg_wdata) : '0)) == '0));

    assert_event_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_evt & HOST_DIRECT_MASK) != '0) |=>
        ((host_stat & $past(host_evt) & HOST_DIRECT_MASK) == ($past(host_evt) & HOST_DIRECT_MASK)));

    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fh_evt[FH_HIPRI_BIT] && host_mask[HB_FH_RX] && !reg_wr) |=> irq);

    assert_fold_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fh_evt[FH_ERR_BIT] |=> host_stat[HB_FH_ERR]);

    assert_periodic_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (per_val == '0 && !host_stat[HB_PERIODIC]) |=> !host_stat[HB_PERIODIC]);

endmodule

bind hirq_coalescer hirq_coalescer_chk #(.COAL_W(COAL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .host_evt (host_evt),
    .fh_evt   (fh_evt),
    .host_stat(host_stat),
    .host_mask(host_mask),
    .per_val  (per_val)
);

// File: tb/hirq_coalescer_tb_top.sv
module hirq_coalescer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] host_evt = '0;
    logic [31:0] fh_evt = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    val;
        string tag;
    } irq_exp_t;

    irq_exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hirq_coalescer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_tick  (us_tick),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .host_evt (host_evt),
        .fh_evt   (fh_evt),
        .irq      (irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // scoreboard monitor: compares the line against queued expectations
    always @(negedge clk) begin : irq_monitor
        irq_exp_t item;
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            item = sb_q.pop_front();
            n_checks++;
            if (item.at != cyc || irq !== item.val) begin
                n_fail++;
                $display("FAIL %s irq actual=%0b expected=%0b at cycle %0d (now %0d)",
                         item.tag, irq, item.val, item.at, cyc);
            end
        end
    end

    task automatic expect_irq(int at, bit val, string tag);
        irq_exp_t item;
        item.at = at;
        item.val = val;
        item.tag = tag;
        sb_q.push_back(item);
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic read_chk(logic [1:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse_host(logic [31:0] v);
        host_evt = v;
        @(negedge clk);
        host_evt = '0;
    endtask

    task automatic pulse_fh(logic [31:0] v);
        fh_evt = v;
        @(negedge clk);
        fh_evt = '0;
    endtask

    task automatic finish_run();
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard R6 actual=%0d expected=0 items left", sb_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        int e;
        int t;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R12 reset values and register indices
        read_chk(2'd0, 32'h0, "R10 host status");
        read_chk(2'd1, 32'h0, "R10 host mask");
        read_chk(2'd2, 32'h0, "R10 fh status");
        read_chk(2'd3, 32'h0000_0040, "R10 R12 control");
        chk("R10 irq", {31'b0, irq}, 32'h0);

        reg_write(2'd1, 32'hFFFF_FFFF);
        read_chk(2'd1, 32'hFFFF_FFFF, "R12 mask readback");
        us_tick = 1'b1;

        // R6 default delay 0x40 units = 2048 ticks
        e = cyc + 1;
        expect_irq(e + 2048, 1'b0, "R6 default delay early");
        expect_irq(e + 2049, 1'b1, "R6 default delay edge");
        pulse_host(32'h0000_0001);
        wait_cyc(e + 2051);
        read_chk(2'd0, 32'h0000_0001, "R4 alive bit");

        // R1 writing 0 leaves the bit
        reg_write(2'd0, 32'h0);
        read_chk(2'd0, 32'h0000_0001, "R1 zero write");
        chk("R11 irq held", {31'b0, irq}, 32'h1);
        reg_write(2'd0, 32'h0000_0001);
        read_chk(2'd0, 32'h0, "R1 clear");
        chk("R11 irq drops", {31'b0, irq}, 32'h0);

        // R6 one-unit delay
        reg_write(2'd3, 32'h0000_0001);
        e = cyc + 1;
        expect_irq(e + 32, 1'b0, "R6 unit delay early");
        expect_irq(e + 33, 1'b1, "R6 unit delay edge");
        pulse_host(32'h0200_0000);
        wait_cyc(e + 40);
        pulse_host(32'h0000_0008);
        reg_write(2'd0, 32'h0200_0000);
        chk("R11 still pending", {31'b0, irq}, 32'h1);
        reg_write(2'd0, 32'h0000_0008);
        chk("R11 all cleared", {31'b0, irq}, 32'h0);
        e = cyc + 1;
        expect_irq(e + 32, 1'b0, "R11 restart early");
        expect_irq(e + 33, 1'b1, "R11 restart edge");
        pulse_host(32'h0000_0002);
        wait_cyc(e + 40);
        reg_write(2'd0, 32'h0000_0002);

        // R6 timer frozen without ticks
        us_tick = 1'b0;
        e = cyc + 1;
        pulse_host(32'h0000_0040);
        wait_cyc(e + 100);
        chk("R6 no tick no fire", {31'b0, irq}, 32'h0);
        t = cyc;
        expect_irq(t + 31, 1'b0, "R6 gated early");
        expect_irq(t + 32, 1'b1, "R6 gated edge");
        us_tick = 1'b1;
        wait_cyc(t + 34);
        reg_write(2'd0, 32'h0000_0040);

        // R7 zero delay
        reg_write(2'd3, 32'h0000_0000);
        e = cyc + 1;
        expect_irq(e, 1'b0, "R7 latch cycle");
        expect_irq(e + 1, 1'b1, "R7 next edge");
        pulse_host(32'h0000_0080);
        wait_cyc(e + 3);
        reg_write(2'd0, 32'h0000_0080);

        // R5 masked cause latches but no line
        reg_write(2'd1, 32'h0000_0001);
        pulse_host(32'h0400_0000);
        repeat (50) @(negedge clk);
        chk("R5 masked no irq", {31'b0, irq}, 32'h0);
        read_chk(2'd0, 32'h0400_0000, "R5 masked latched");
        reg_write(2'd0, 32'hFFFF_FFFF);

        // R2 / R3 flow-handler latch and fold
        pulse_fh(32'h8002_0022);
        read_chk(2'd0, 32'hA800_0000, "R3 fold");
        read_chk(2'd2, 32'h8002_0002, "R2 fh latch");
        reg_write(2'd2, 32'h0002_0000);
        read_chk(2'd2, 32'h8000_0002, "R2 fh w1c");
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_write(2'd0, 32'hFFFF_FFFF);
        read_chk(2'd2, 32'h0, "R2 fh cleared");

        // R8 bypass under maximum delay
        reg_write(2'd3, 32'h0000_00FF);
        reg_write(2'd1, 32'h8000_0000);
        e = cyc + 1;
        expect_irq(e, 1'b1, "R8 bypass");
        pulse_fh(32'h4000_0000);
        read_chk(2'd2, 32'h4000_0000, "R2 hi-pri latch");
        read_chk(2'd0, 32'h8000_0000, "R3 hi-pri fold");
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_write(2'd2, 32'hFFFF_FFFF);
        chk("R11 bypass cleared", {31'b0, irq}, 32'h0);
        e = cyc + 1;
        expect_irq(e, 1'b0, "R8 plain rx no bypass");
        expect_irq(e + 5, 1'b0, "R8 plain rx waits");
        pulse_fh(32'h0001_0000);
        wait_cyc(e + 6);
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_write(2'd2, 32'hFFFF_FFFF);

        // R4 ignored and accepted direct bits
        reg_write(2'd1, 32'h0);
        pulse_host(32'hB800_0030);
        read_chk(2'd0, 32'h0, "R4 ignored bits");
        pulse_host(32'hFFFF_FFFF);
        read_chk(2'd0, 32'h0600_00CB, "R4 direct mask");
        reg_write(2'd0, 32'hFFFF_FFFF);

        // R1 event wins over simultaneous clear
        host_evt = 32'h0000_0001;
        reg_wr = 1'b1;
        reg_addr = 2'd0;
        reg_wdata = 32'h0000_0001;
        @(negedge clk);
        host_evt = '0;
        reg_wr = 1'b0;
        reg_wdata = '0;
        read_chk(2'd0, 32'h0000_0001, "R1 event wins");
        reg_write(2'd0, 32'hFFFF_FFFF);

        // R9 periodic with P=1
        w = cyc + 1;
        reg_write(2'd3, 32'h0000_0100);
        wait_cyc(w + 32);
        read_chk(2'd0, 32'h0, "R9 before first expiry");
        wait_cyc(w + 33);
        read_chk(2'd0, 32'h1000_0000, "R9 first expiry");
        reg_write(2'd0, 32'h1000_0000);
        wait_cyc(w + 64);
        read_chk(2'd0, 32'h0, "R9 before second expiry");
        wait_cyc(w + 65);
        read_chk(2'd0, 32'h1000_0000, "R9 second expiry");
        reg_write(2'd3, 32'h0000_0000);
        reg_write(2'd0, 32'hFFFF_FFFF);
        repeat (200) @(negedge clk);
        read_chk(2'd0, 32'h0, "R9 disabled");

        done = 1'b1;
        finish_run();
    end

endmodule